// File: doc/BRIEF.md
# Deferred-Write Store Buffer for a Set-Associative Data Cache

This block controls access to the data storage of a four-way set-associative cache with a single request port. Each cycle the data array offers one access window, and loads and stores share it. A load reads every way of the addressed word speculatively while the tags are compared. The result is used only when a way hits. A store compares tags in its own cycle and cannot write the array then, because the write depends on that comparison. A store that hits is parked in a one-entry store-hit buffer. The parked entry is copied into the array during the otherwise idle window of the next store that hits. Until then, loads to the parked word receive the buffered bytes merged over the array contents.

The buffer is a two-state machine. The states are `BUF_EMPTY` and `BUF_HELD`. The transitions are:
- capture: `BUF_EMPTY` to `BUF_HELD` on a store hit.
- replace: `BUF_HELD` to `BUF_HELD` on a store hit. The old entry drains and the new one is captured.
- hold: `BUF_HELD` to `BUF_HELD` on any other request.
- flush: `BUF_HELD` to `BUF_EMPTY` when a line install targets the buffered set and way. The entry drains first.

A line-install port writes one word together with the tag and valid bit of its line, and is used to preload contents. Miss handling and refill are not part of the block.

Top module: `dwc_cache`

## Requirements
- R1: After reset no line is valid. `rsp_valid` is low, and a load returns `rsp_hit`=0 with `rsp_rdata`=0.
- R2: A load accepted in cycle t gives `rsp_valid`=1 in cycle t+1 and in no other cycle. `rsp_hit` is 1 exactly when a valid way holds the load's tag. On a miss, `rsp_rdata` is zero.
- R3: A store hit is visible to the very next load of the same word. Bit i of `req_be` selects bits [8i+7:8i]. Bytes that are not enabled keep their old value.
- R4: A parked store reaches the array when the next store hit arrives, and stays visible after later stores to other words.
- R5: A store that misses changes neither the array nor the buffer. An entry that is already parked stays forwardable.
- R6: Back-to-back store hits to one word combine. Each byte holds the value of the latest store that enabled it.
- R7: An install writes all 8 bytes of one word into the given way and marks the line valid. A line is filled by four installs.
- R8: An install to the buffered set and way first drains the parked data into the array. If both touch the same word, the install data wins.
- R9: While `inst_valid` is high, the request port is ignored. No response is produced and no store takes effect.
- R10: Address fields are as follows. Bits [2:0] are the byte offset and are ignored. Bits [4:3] select the word, bits [11:5] select the set, and bits [19:12] are the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| rsp_valid | output | 1 | Load response valid |
| rsp_hit | output | 1 | Load hit a valid way |
| rsp_rdata | output | 64 | Load data |
| inst_valid | input | 1 | Install one word of a line |
| inst_way | input | 2 | Target way |
| inst_addr | input | 20 | Address of the installed word |
| inst_wdata | input | 64 | Installed word |

## Verification
Several stimulus patterns are used, and each separates a different fault:
- A store followed at once by a load of the same word separates a working forwarding path from one that reads only the array.
- A store hit to another line followed by a load of the first word separates a correct drain from a lost write.
- A store miss between a store and its load shows whether a miss disturbs the parked entry.
- Two partial stores to one word with complementary enables expose wrong byte merging.
- An install that targets the parked line, with words that differ and words that coincide, checks the drain-before-install ordering.

Requests issued alongside installs check that they are ignored. A long seeded random mix of hitting and missing loads and stores is compared against a flat reference memory.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
    typedef enum logic [0:0] {
        BUF_EMPTY = 1'b0,
        BUF_HELD  = 1'b1
    } buf_state_e;
endpackage

// File: rtl/dwc_tag_store.sv
module dwc_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 128,
    parameter int TAG_W = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inst_en,
    input  logic [SET_W-1:0] inst_set,
    input  logic [WAY_W-1:0] inst_way,
    input  logic [TAG_W-1:0] inst_tag,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  hit_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (inst_en) begin
            vld_q[inst_set][inst_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en) tag_q[inst_set][inst_way] <= inst_tag;
    end

    always_comb begin
        lk_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
            if (hit_vec[w]) lk_way = WAY_W'(w);
        end
        lk_hit = |hit_vec;
    end

    // R7: an install leaves its line valid
    p_install_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inst_en |=> vld_q[$past(inst_set)][$past(inst_way)]);
endmodule

// File: rtl/dwc_data_bank.sv
module dwc_data_bank #(
    parameter int WAYS = 4,
    parameter int SETS = 128,
    parameter int DW   = 64,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS),
    localparam int BE_W  = DW / 8
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [WAY_W-1:0]         wr_way,
    input  logic [SET_W-1:0]         wr_set,
    input  logic [DW-1:0]            wr_data,
    input  logic [BE_W-1:0]          wr_be,
    input  logic                     rd_en,
    input  logic [SET_W-1:0]         rd_set,
    output logic [WAYS-1:0][DW-1:0]  rd_data
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DW-1:0] mem [SETS];
        logic [DW-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_W'(w)) begin
                for (int b = 0; b < BE_W; b++)
                    if (wr_be[b]) mem[wr_set][8*b +: 8] <= wr_data[8*b +: 8];
            end
            if (rd_en) rd_q <= mem[rd_set];
        end
        assign rd_data[w] = rd_q;
    end
endmodule

// File: rtl/dwc_hit_buffer.sv
module dwc_hit_buffer
    import dwc_pkg::*;
#(
    parameter int WAY_W  = 2,
    parameter int SET_W  = 7,
    parameter int WORD_W = 2,
    parameter int DW     = 64,
    localparam int BE_W  = DW / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_hit,
    input  logic [WAY_W-1:0]  st_way,
    input  logic [SET_W-1:0]  st_set,
    input  logic [WORD_W-1:0] st_word,
    input  logic [DW-1:0]     st_data,
    input  logic [BE_W-1:0]   st_be,
    input  logic              inst_en,
    input  logic [SET_W-1:0]  inst_set,
    input  logic [WAY_W-1:0]  inst_way,
    input  logic [WAY_W-1:0]  q_way,
    input  logic [SET_W-1:0]  q_set,
    input  logic [WORD_W-1:0] q_word,
    output logic              drain_en,
    output logic [WAY_W-1:0]  drain_way,
    output logic [SET_W-1:0]  drain_set,
    output logic [WORD_W-1:0] drain_word,
    output logic [DW-1:0]     drain_data,
    output logic [BE_W-1:0]   drain_be,
    output logic              fwd_hit,
    output logic [DW-1:0]     buf_data,
    output logic [BE_W-1:0]   buf_be
);
    buf_state_e        state_q, state_d;
    logic [WAY_W-1:0]  b_way;
    logic [SET_W-1:0]  b_set;
    logic [WORD_W-1:0] b_word;
    logic [DW-1:0]     b_data;
    logic [BE_W-1:0]   b_be;
    logic              inst_line;

    assign inst_line = inst_en && (inst_set == b_set) && (inst_way == b_way);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: if (st_hit) state_d = BUF_HELD;
            BUF_HELD:  if (!st_hit && inst_line) state_d = BUF_EMPTY;
            default:   state_d = BUF_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUF_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_way <= '0; b_set <= '0; b_word <= '0; b_data <= '0; b_be <= '0;
        end else if (st_hit) begin
            b_way <= st_way; b_set <= st_set; b_word <= st_word;
            b_data <= st_data; b_be <= st_be;
        end
    end

    always_comb begin
        drain_en = 1'b0;
        fwd_hit  = 1'b0;
        unique case (state_q)
            BUF_EMPTY: ;
            BUF_HELD: begin
                drain_en = st_hit || inst_line;
                fwd_hit  = (q_set == b_set) && (q_way == b_way) && (q_word == b_word);
            end
            default: ;
        endcase
    end

    assign drain_way  = b_way;
    assign drain_set  = b_set;
    assign drain_word = b_word;
    assign drain_data = b_data;
    assign drain_be   = b_be;
    assign buf_data   = b_data;
    assign buf_be     = b_be;

    // R3: a store hit is parked with its data
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_hit |=> (state_q == BUF_HELD) && (b_data == $past(st_data)));
    // R5: other requests leave a parked entry untouched
    p_miss_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_HELD && !st_hit && !inst_en) |=>
        (state_q == BUF_HELD) && $stable(b_data) && $stable(b_set) && $stable(b_be));
    // R8: an install over the parked line empties the buffer
    p_inst_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_HELD && inst_line && !st_hit) |=> state_q == BUF_EMPTY);
endmodule

// File: rtl/dwc_cache.sv
module dwc_cache #(
    parameter int ADDR_W      = 20,
    parameter int DW          = 64,
    parameter int CACHE_BYTES = 16384,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 32,
    localparam int BE_W   = DW / 8,
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DW-1:0]     rsp_rdata,
    input  logic              inst_valid,
    input  logic [WAY_W-1:0]  inst_way,
    input  logic [ADDR_W-1:0] inst_addr,
    input  logic [DW-1:0]     inst_wdata
);
    localparam int OFF_W  = $clog2(BE_W);
    localparam int WPL    = LINE_BYTES / BE_W;
    localparam int WORD_W = $clog2(WPL);
    localparam int SETS   = CACHE_BYTES / (WAYS * LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - WORD_W - SET_W;
    localparam int SET_LO = OFF_W + WORD_W;
    localparam int TAG_LO = SET_LO + SET_W;

    logic [WORD_W-1:0] req_word, inst_word;
    logic [SET_W-1:0]  req_set, inst_set;
    logic [TAG_W-1:0]  req_tag, inst_tag;
    assign req_word  = req_addr[OFF_W +: WORD_W];
    assign req_set   = req_addr[SET_LO +: SET_W];
    assign req_tag   = req_addr[TAG_LO +: TAG_W];
    assign inst_word = inst_addr[OFF_W +: WORD_W];
    assign inst_set  = inst_addr[SET_LO +: SET_W];
    assign inst_tag  = inst_addr[TAG_LO +: TAG_W];

    logic ld_go, st_go, lk_hit, st_hit, fwd_hit;
    logic [WAY_W-1:0] lk_way;
    assign ld_go  = req_valid && !req_write && !inst_valid;
    assign st_go  = req_valid &&  req_write && !inst_valid;
    assign st_hit = st_go && lk_hit;

    dwc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .inst_en(inst_valid), .inst_set(inst_set), .inst_way(inst_way), .inst_tag(inst_tag),
        .lk_set(req_set), .lk_tag(req_tag), .lk_hit(lk_hit), .lk_way(lk_way)
    );

    logic              drain_en;
    logic [WAY_W-1:0]  drain_way;
    logic [SET_W-1:0]  drain_set;
    logic [WORD_W-1:0] drain_word;
    logic [DW-1:0]     drain_data, buf_data;
    logic [BE_W-1:0]   drain_be, buf_be;

    dwc_hit_buffer #(.WAY_W(WAY_W), .SET_W(SET_W), .WORD_W(WORD_W), .DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .st_hit(st_hit), .st_way(lk_way), .st_set(req_set), .st_word(req_word),
        .st_data(req_wdata), .st_be(req_be),
        .inst_en(inst_valid), .inst_set(inst_set), .inst_way(inst_way),
        .q_way(lk_way), .q_set(req_set), .q_word(req_word),
        .drain_en(drain_en), .drain_way(drain_way), .drain_set(drain_set),
        .drain_word(drain_word), .drain_data(drain_data), .drain_be(drain_be),
        .fwd_hit(fwd_hit), .buf_data(buf_data), .buf_be(buf_be)
    );

    logic [WPL-1:0][WAYS-1:0][DW-1:0] bank_rd;

    for (genvar b = 0; b < WPL; b++) begin : g_bank
        logic inst_here, drain_here;
        assign inst_here  = inst_valid && (inst_word == WORD_W'(b));
        assign drain_here = drain_en && (drain_word == WORD_W'(b));
        dwc_data_bank #(.WAYS(WAYS), .SETS(SETS), .DW(DW)) u_bank (
            .clk(clk),
            .wr_en(inst_here || drain_here),
            .wr_way(inst_here ? inst_way : drain_way),
            .wr_set(inst_here ? inst_set : drain_set),
            .wr_data(inst_here ? inst_wdata : drain_data),
            .wr_be(inst_here ? {BE_W{1'b1}} : drain_be),
            .rd_en(ld_go && (req_word == WORD_W'(b))),
            .rd_set(req_set),
            .rd_data(bank_rd[b])
        );
    end

    logic              hit_q, fwd_q;
    logic [WAY_W-1:0]  way_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0; hit_q <= 1'b0; fwd_q <= 1'b0; way_q <= '0; word_q <= '0;
        end else begin
            rsp_valid <= ld_go;
            hit_q     <= ld_go && lk_hit;
            fwd_q     <= ld_go && lk_hit && fwd_hit;
            way_q     <= lk_way;
            word_q    <= req_word;
        end
    end

    always_comb begin
        rsp_rdata = '0;
        if (hit_q) begin
            for (int i = 0; i < BE_W; i++)
                rsp_rdata[8*i +: 8] = (fwd_q && buf_be[i]) ? buf_data[8*i +: 8]
                                                           : bank_rd[word_q][way_q][8*i +: 8];
        end
    end
    assign rsp_hit = hit_q;

    // R2: one response, one cycle after an accepted load
    p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !inst_valid) |=> rsp_valid);
    // R9: no response unless a load was accepted
    p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid || !req_valid || req_write) |=> !rsp_valid);
    // R2: a missing load returns zero
    p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_rdata == '0));
endmodule

// File: tb/dwc_cache_bench.sv
module dwc_cache_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0;
    logic [19:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_be = '0;
    logic        rsp_valid, rsp_hit;
    logic [63:0] rsp_rdata;
    logic        inst_valid = 0;
    logic [1:0]  inst_way = '0;
    logic [19:0] inst_addr = '0;
    logic [63:0] inst_wdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dwc_cache u_dwc_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .inst_valid(inst_valid), .inst_way(inst_way), .inst_addr(inst_addr),
        .inst_wdata(inst_wdata)
    );

    int n_checks = 0, n_err = 0;
    bit done = 0;

    logic [63:0] ref_mem [8][4][4];
    bit          present [8][4];
    int          way_tag [4][4];

    logic        exp_v = 0, exp_h = 0;
    logic [63:0] exp_d = '0;
    string       exp_r = "R1";

    function automatic logic [19:0] mk_addr(int t, int s, int w, int off);
        return {8'(t), 7'(s), 2'(w), 3'(off)};
    endfunction

    function automatic logic [63:0] pat(int t, int s, int w);
        return {8'(t), 8'(s), 8'(w), 8'hC3, 32'h0F1E2D3C ^ 32'(t*97 + s*13 + w)};
    endfunction

    task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic check_prev();
        chk(rsp_valid == exp_v, exp_r, 64'(rsp_valid), 64'(exp_v));
        if (exp_v && rsp_valid) begin
            chk(rsp_hit == exp_h, exp_r, 64'(rsp_hit), 64'(exp_h));
            chk(rsp_rdata == exp_d, exp_r, rsp_rdata, exp_d);
        end
    endtask

    task automatic clear_inputs();
        req_valid = 0; req_write = 0; inst_valid = 0;
    endtask

    task automatic op_idle();
        @(negedge clk); check_prev(); clear_inputs();
        exp_v = 0;
    endtask

    task automatic op_load(int t, int s, int w, string r);
        @(negedge clk); check_prev(); clear_inputs();
        req_valid = 1; req_write = 0; req_addr = mk_addr(t, s, w, $urandom % 8);
        exp_v = 1; exp_h = present[t][s]; exp_r = r;
        exp_d = exp_h ? ref_mem[t][s][w] : '0;
    endtask

    task automatic op_store(int t, int s, int w, logic [63:0] d, logic [7:0] be);
        @(negedge clk); check_prev(); clear_inputs();
        req_valid = 1; req_write = 1; req_addr = mk_addr(t, s, w, $urandom % 8);
        req_wdata = d; req_be = be;
        if (present[t][s])
            for (int b = 0; b < 8; b++)
                if (be[b]) ref_mem[t][s][w][8*b +: 8] = d[8*b +: 8];
        exp_v = 0;
    endtask

    // side: 0 none, 1 concurrent load, 2 concurrent store (both must be ignored, R9)
    task automatic op_install(int t, int s, int wy, int w, logic [63:0] d, int side);
        @(negedge clk); check_prev(); clear_inputs();
        inst_valid = 1; inst_way = 2'(wy); inst_addr = mk_addr(t, s, w, 0); inst_wdata = d;
        if (side != 0) begin
            req_valid = 1; req_write = (side == 2); req_addr = mk_addr(0, 0, 0, 0);
            req_wdata = '1; req_be = '1;
        end
        if (way_tag[s][wy] >= 0 && way_tag[s][wy] != t) present[way_tag[s][wy]][s] = 0;
        way_tag[s][wy] = t; present[t][s] = 1; ref_mem[t][s][w] = d;
        exp_v = 0; exp_r = "R9";
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int s = 0; s < 4; s++) for (int wy = 0; wy < 4; wy++) way_tag[s][wy] = -1;
        for (int t = 0; t < 8; t++) for (int s = 0; s < 4; s++) begin
            present[t][s] = 0;
            for (int w = 0; w < 4; w++) ref_mem[t][s][w] = '0;
        end
        repeat (3) @(posedge clk);
        rst_n = 1;
        // R1: nothing valid after reset
        op_load(0, 0, 0, "R1");
        op_load(3, 2, 1, "R1");
        // R7: fill lines, tag t into way t
        for (int t = 0; t < 4; t++) for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++)
            op_install(t, s, t, w, pat(t, s, w), 0);
        // R9: requests alongside installs are ignored
        op_install(3, 3, 3, 3, pat(3, 3, 3), 1);
        op_install(3, 3, 3, 2, pat(3, 3, 2), 2);
        // R7, R10: read back every word with random byte offsets
        for (int t = 0; t < 4; t++) for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++)
            op_load(t, s, w, "R7");
        op_load(5, 1, 0, "R2");
        // R3: forward right after a partial store
        op_store(1, 1, 2, 64'h1111_2222_3333_4444, 8'h0F);
        op_load(1, 1, 2, "R3");
        op_load(1, 1, 3, "R3");
        // R4: next store hit drains the first
        op_store(2, 0, 1, 64'hAAAA_BBBB_CCCC_DDDD, 8'hFF);
        op_load(1, 1, 2, "R4");
        op_load(2, 0, 1, "R4");
        op_store(0, 3, 0, 64'h5, 8'h01);
        op_load(2, 0, 1, "R4");
        // R5: a miss leaves the parked entry in place
        op_store(6, 0, 0, 64'hDEAD_BEEF_0000_0001, 8'hFF);
        op_load(0, 3, 0, "R5");
        op_load(6, 0, 0, "R5");
        // R6: back-to-back partial stores to one word
        op_store(3, 2, 3, 64'h0102_0304_0506_0708, 8'h0F);
        op_store(3, 2, 3, 64'hF0E0_D0C0_B0A0_9080, 8'hF0);
        op_load(3, 2, 3, "R6");
        op_store(3, 2, 3, 64'h0000_0000_0000_7700, 8'h02);
        op_load(3, 2, 3, "R6");
        // R8: install into the parked line, other word then same word
        op_store(1, 2, 1, 64'h0BAD_F00D_1234_5678, 8'hFF);
        op_install(1, 2, 1, 3, 64'h3333_3333_3333_3333, 0);
        op_load(1, 2, 1, "R8");
        op_load(1, 2, 3, "R8");
        op_store(2, 3, 0, 64'h7777_7777_7777_7777, 8'hFF);
        op_install(2, 3, 2, 0, 64'h9999_8888_7777_6666, 0);
        op_load(2, 3, 0, "R8");
        // random mix against the flat reference
        for (int i = 0; i < 3000; i++) begin
            int t, s, w;
            t = $urandom % 6; s = $urandom % 4; w = $urandom % 4;
            if ($urandom % 10 < 6) op_load(t, s, w, "R2");
            else op_store(t, s, w, {$urandom, $urandom}, 8'($urandom));
        end
        op_idle();
        op_idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule